// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Access Controller

This block is a hardware SPI master that carries out single-byte operations on a byte-wide serial EEPROM. A host raises a one-cycle request with a small operation code, a 16-bit address and a write byte. The controller then runs a whole framed transaction on the serial pins. It drives the serial clock, the outgoing data line and an active-low select, and it samples the incoming data line. The block builds the command byte itself from the fixed EEPROM command set.

Each access is one unbroken frame. The select stays low from before the first command bit until after the last data bit. The serial bit period is a programmable number of system clocks. The divisor is captured when a request is accepted, so changing it during a frame has no effect. When the select is released, a one-cycle completion pulse marks the end of the frame, and any byte read is presented on a held output.

Top module: `spi_eeprom_master`

## Requirements
- R1: Host operation codes map to command bytes as follows: 0 = array read (0x03), 1 = array write (0x02), 2 = status read (0x05), 3 = status write (0x01), 4 = enable writes (0x06), 5 = disable writes (0x04). Each frame starts with its command byte, sent MSB first.
- R2: An array read or array write is one 32-bit frame: the command byte, then the 16-bit address MSB first, then the 8-bit data byte MSB first. The data byte is the write byte, or whatever is shifted out during a read.
- R3: A status read or status write frame is 16 bits long: the command byte, then 8 bits. For a status write, those 8 bits are the write byte. A write-enable or write-disable frame is 8 bits long.
- R4: Each accepted request produces exactly one interval with the select low. Every serial clock rising edge of the frame falls inside that interval.
- R5: The serial clock follows SPI mode 0. It is low whenever the select is high. Outgoing data changes only while the clock is low, and incoming data is sampled on rising edges.
- R6: One serial bit lasts D+1 system clocks, where D is the divisor input captured at acceptance. A divisor of 0 is treated as 1. Within each bit, the clock is low for floor((D+1)/2) system clocks and then high for the rest of the bit.
- R7: The first rising edge comes D+1+floor((D+1)/2) system clocks after the select falls. This gives one full bit period of setup before the first bit.
- R8: On an array read, the last 8 bits sampled from the incoming data line (MSB first) appear on the read-data output when the completion pulse is high. On a status read, the 8 bits that follow the command byte appear there in the same way.
- R9: The read-data output changes only at the completion of a read frame. Write, status-write and enable/disable frames leave it unchanged.
- R10: The completion pulse is high for exactly one system clock, in the same cycle that the select returns high.
- R11: After each frame, the select stays high for at least D+1 system clocks before the next frame. Busy is high from the cycle after acceptance until this gap ends.
- R12: A request made while busy is high is ignored. A request with operation code 6 or 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only while idle |
| op | input | 3 | Host operation code (see R1) |
| addr | input | 16 | Array address |
| wdata | input | 8 | Byte to write (array or status) |
| div | input | 8 | Serial bit period minus one, in system clocks |
| busy | output | 1 | Transaction in progress, including the release gap |
| done | output | 1 | One-cycle pulse when the select is released |
| rdata | output | 8 | Last byte read, held between reads |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the EEPROM |
| miso | input | 1 | Serial data from the EEPROM |
| cs_n | output | 1 | Active-low EEPROM select |

## Verification
Some properties are checked by assertions on every cycle:
- the clock is low while the select is high;
- outgoing data is stable while the clock is high;
- every rising edge falls inside a select-low interval;
- the completion pulse lasts one cycle and coincides with the select release;
- read data changes only at completion;
- the bit phase counter stays within the divisor.

Other properties can only be shown by the bench scenarios, which sweep every operation code across several divisors, including 0. These are the bit content and length of each frame, the rising-edge spacing and setup delay, the byte returned from a modelled EEPROM, the release gap, and whether requests made mid-frame or with unused codes are ignored.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   localparam int CMD_W = 8;

   typedef enum logic [2:0] {
      OP_RD_ARRAY = 3'd0,
      OP_WR_ARRAY = 3'd1,
      OP_RD_STAT  = 3'd2,
      OP_WR_STAT  = 3'd3,
      OP_WEL_SET  = 3'd4,
      OP_WEL_CLR  = 3'd5
   } host_op_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_SETUP = 2'd1,
      S_XFER  = 2'd2,
      S_GAP   = 2'd3
   } seq_state_e;

   function automatic logic [CMD_W-1:0] cmd_byte(input logic [2:0] op);
      case (op)
         OP_RD_ARRAY: cmd_byte = 8'h03;
         OP_WR_ARRAY: cmd_byte = 8'h02;
         OP_RD_STAT:  cmd_byte = 8'h05;
         OP_WR_STAT:  cmd_byte = 8'h01;
         OP_WEL_SET:  cmd_byte = 8'h06;
         OP_WEL_CLR:  cmd_byte = 8'h04;
         default:     cmd_byte = 8'h00;
      endcase
   endfunction

   function automatic logic op_valid(input logic [2:0] op);
      op_valid = (op <= 3'd5);
   endfunction

   function automatic logic op_reads(input logic [2:0] op);
      op_reads = (op == OP_RD_ARRAY) || (op == OP_RD_STAT);
   endfunction

endpackage

// File: rtl/spi_ee_bitclk.sv
module spi_ee_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bit_last,
   output logic             sample,
   output logic             sck_nxt
);

   logic [DIV_W-1:0] ph;
   logic [DIV_W-1:0] ph_nxt;
   logic [DIV_W:0]   half;

   assign half     = ({1'b0, div} + 1'b1) >> 1;
   assign bit_last = run && (ph == div);
   assign ph_nxt   = bit_last ? '0 : ph + 1'b1;
   assign sample   = run && !bit_last && ({1'b0, ph_nxt} == half);
   assign sck_nxt  = run && ({1'b0, ph_nxt} >= half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ph <= '0;
      else if (!run) ph <= '0;
      else          ph <= ph_nxt;
   end

   // R6
   ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ph <= div));

endmodule

// File: rtl/spi_ee_seq.sv
module spi_ee_seq
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              miso,
   input  logic              bit_last,
   input  logic              sample,
   input  logic              sck_nxt,
   output logic              accept,
   output logic              run,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   seq_state_e         state;
   logic [FRAME_W-1:0] tx_sr;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nleft;
   logic [CNT_W-1:0]   nbits;
   logic               rd_op;
   logic [DATA_W-1:0]  rx_sr;

   always_comb begin
      case (op)
         OP_RD_ARRAY, OP_WR_ARRAY: begin
            frame = {cmd_byte(op), addr, wdata};
            nbits = CNT_W'(FRAME_W);
         end
         OP_WR_STAT: begin
            frame = {cmd_byte(op), wdata, {ADDR_W{1'b0}}};
            nbits = CNT_W'(CMD_W + DATA_W);
         end
         OP_RD_STAT: begin
            frame = {cmd_byte(op), {(ADDR_W + DATA_W){1'b0}}};
            nbits = CNT_W'(CMD_W + DATA_W);
         end
         default: begin
            frame = {cmd_byte(op), {(ADDR_W + DATA_W){1'b0}}};
            nbits = CNT_W'(CMD_W);
         end
      endcase
   end

   assign accept = (state == S_IDLE) && req && op_valid(op);
   assign run    = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         tx_sr <= '0;
         nleft <= '0;
         rd_op <= 1'b0;
         rx_sr <= '0;
         rdata <= '0;
         sck   <= 1'b0;
         mosi  <= 1'b0;
         cs_n  <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (accept) begin
                  state <= S_SETUP;
                  tx_sr <= frame;
                  nleft <= nbits;
                  rd_op <= op_reads(op);
                  cs_n  <= 1'b0;
                  mosi  <= frame[FRAME_W-1];
               end
            end
            S_SETUP: begin
               if (bit_last) state <= S_XFER;
            end
            S_XFER: begin
               sck <= sck_nxt;
               if (sample) rx_sr <= {rx_sr[DATA_W-2:0], miso};
               if (bit_last) begin
                  if (nleft == CNT_W'(1)) begin
                     state <= S_GAP;
                     cs_n  <= 1'b1;
                     mosi  <= 1'b0;
                     done  <= 1'b1;
                     if (rd_op) rdata <= rx_sr;
                  end else begin
                     nleft <= nleft - 1'b1;
                     tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                     mosi  <= tx_sr[FRAME_W-2];
                  end
               end
            end
            S_GAP: begin
               if (bit_last) state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R5
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R5
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R4
   edge_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> (!cs_n && !$past(cs_n)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !$past(cs_n)));

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata) |-> done);

endmodule

// File: rtl/spi_eeprom_master.sv
module spi_eeprom_master #(
   parameter int DIV_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DIV_W-1:0]  div,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
         $error("DIV_W must be within 1..16");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_eff;
   logic             accept;
   logic             run;
   logic             bit_last;
   logic             sample;
   logic             sck_nxt;

   assign div_eff = (div == '0) ? DIV_W'(1) : div;
   assign busy    = run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= DIV_W'(1);
      else if (accept) div_q <= div_eff;
   end

   spi_ee_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div      (div_q),
      .bit_last (bit_last),
      .sample   (sample),
      .sck_nxt  (sck_nxt)
   );

   spi_ee_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .op       (op),
      .addr     (addr),
      .wdata    (wdata),
      .miso     (miso),
      .bit_last (bit_last),
      .sample   (sample),
      .sck_nxt  (sck_nxt),
      .accept   (accept),
      .run      (run),
      .sck      (sck),
      .mosi     (mosi),
      .cs_n     (cs_n),
      .done     (done),
      .rdata    (rdata)
   );

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req) |=> $stable(div_q));

endmodule

// File: tb/spi_eeprom_master_bench.sv
module spi_eeprom_master_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [15:0] addr = 16'h0;
   logic [7:0]  wdata = 8'h0;
   logic [7:0]  div = 8'd1;
   logic        busy, done, sck, mosi, cs_n;
   logic        miso = 1'b1;
   logic [7:0]  rdata;

   always #2.5 clk = ~clk;

   spi_eeprom_master u_spi_eeprom_master (
      .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
      .wdata(wdata), .div(div), .busy(busy), .done(done), .rdata(rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   int total = 0;
   int bad = 0;

   // monitor state
   int          cyc = 0;
   int          txn_div = 1;
   logic [2:0]  cur_op = 3'd0;
   logic [7:0]  resp = 8'h0;
   logic        prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
   int          cs_fall_cyc = 0, cs_rise_cyc = 0, last_rise = 0;
   int          nrise = 0, first_gap = 0, n_falls = 0;
   int          per_bad = 0, done_bad = 0, mosi_bad = 0, idle_bad = 0, gap_bad = 0;
   int          gap_need = 0, hi_bad = 0, hi_len = 0;
   logic [31:0] rx_bits = 32'h0;
   logic        seen_rise = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (prev_cs && !cs_n) begin
         if (seen_rise && (cyc - cs_rise_cyc < gap_need)) gap_bad++;
         cs_fall_cyc = cyc;
         nrise = 0;
         n_falls++;
      end
      if (!prev_cs && cs_n) begin
         cs_rise_cyc = cyc;
         gap_need = txn_div + 1;
         seen_rise = 1'b1;
         if (!done) done_bad++;
      end
      if (done && !(!prev_cs && cs_n)) done_bad++;
      if (cs_n && sck) idle_bad++;
      if (prev_sck && sck && (mosi != prev_mosi)) mosi_bad++;
      if (sck) hi_len++;
      if (prev_sck && !sck) begin
         if (hi_len != txn_div + 1 - (txn_div + 1) / 2) hi_bad++;
         hi_len = 0;
      end
      if (!prev_sck && sck) begin
         if (nrise == 0) first_gap = cyc - cs_fall_cyc;
         else if (cyc - last_rise != txn_div + 1) per_bad++;
         last_rise = cyc;
         rx_bits = {rx_bits[30:0], mosi};
         nrise++;
      end
      // modelled EEPROM output for the next bit index
      miso = 1'b1;
      if (cur_op == 3'd0 && nrise >= 24 && nrise < 32) miso = resp[31 - nrise];
      if (cur_op == 3'd2 && nrise >= 8 && nrise < 16) miso = resp[15 - nrise];
      prev_cs = cs_n;
      prev_sck = sck;
      prev_mosi = mosi;
   end

   function automatic logic [7:0] exp_cmd(input logic [2:0] o);
      case (o)
         3'd0: exp_cmd = 8'h03;
         3'd1: exp_cmd = 8'h02;
         3'd2: exp_cmd = 8'h05;
         3'd3: exp_cmd = 8'h01;
         3'd4: exp_cmd = 8'h06;
         default: exp_cmd = 8'h04;
      endcase
   endfunction

   function automatic int exp_len(input logic [2:0] o);
      if (o <= 3'd1) exp_len = 32;
      else if (o <= 3'd3) exp_len = 16;
      else exp_len = 8;
   endfunction

   function automatic logic [31:0] exp_frame(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d);
      if (o <= 3'd1) exp_frame = {exp_cmd(o), a, d};
      else if (o == 3'd3) exp_frame = {16'h0, exp_cmd(o), d};
      else if (o == 3'd2) exp_frame = {16'h0, exp_cmd(o), 8'h00};
      else exp_frame = {24'h0, exp_cmd(o)};
   endfunction

   task automatic run_txn(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d,
                          input logic [7:0] r, input bit poke, input bit jiggle_div);
      int d_eff;
      int n;
      int falls0;
      logic [7:0] rd_before;
      logic [31:0] mask;
      d_eff = (div == 8'd0) ? 1 : int'(div);
      @(negedge clk);
      txn_div = d_eff;
      cur_op = o;
      resp = r;
      per_bad = 0; done_bad = 0; mosi_bad = 0; idle_bad = 0; hi_bad = 0;
      falls0 = n_falls;
      rd_before = rdata;
      op = o; addr = a; wdata = d; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         op = (o == 3'd5) ? 3'd0 : o + 3'd1;
         addr = ~a; wdata = ~d; req = 1'b1;
         @(negedge clk);
         req = 1'b0;
      end
      if (jiggle_div) begin
         repeat (2) @(negedge clk);
         div = div + 8'd3;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      n = exp_len(o);
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
      // R1 R2 R3 frame content and length
      chk((rx_bits & mask) == exp_frame(o, a, d), "R1/R2 frame bits", rx_bits & mask, exp_frame(o, a, d));
      chk(nrise == n, "R3 frame length", nrise, n);
      // R4 one select interval per request; R12 mid-frame request ignored
      chk(n_falls - falls0 == 1, "R4 R12 select intervals", n_falls - falls0, 1);
      // R5 and R6 bit timing
      chk(idle_bad == 0 && mosi_bad == 0, "R5 mode 0 violations", idle_bad + mosi_bad, 0);
      chk(per_bad == 0 && hi_bad == 0, "R6 bit period", per_bad + hi_bad, 0);
      // R7 setup delay
      chk(first_gap == d_eff + 1 + (d_eff + 1) / 2, "R7 setup", first_gap, d_eff + 1 + (d_eff + 1) / 2);
      // R10 completion pulse
      chk(done_bad == 0, "R10 done pulse", done_bad, 0);
      // R8 / R9 read data
      if (o == 3'd0 || o == 3'd2) chk(rdata == r, "R8 read byte", rdata, r);
      else chk(rdata == rd_before, "R9 rdata held", rdata, rd_before);
      if (jiggle_div) div = div - 8'd3;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] divs [6];
      divs = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd8};
      repeat (3) @(negedge clk);
      // reset state (R5 R10 R11)
      chk(cs_n == 1'b1 && sck == 1'b0, "R5 reset pins", {cs_n, sck}, 2'b10);
      chk(busy == 1'b0 && done == 1'b0, "R11 reset busy", {busy, done}, 2'b00);
      chk(rdata == 8'h00, "R9 reset rdata", rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         div = divs[i];
         for (int o = 0; o < 6; o++) begin
            run_txn(3'(o), 16'hA5C3 ^ 16'(i * 257), 8'h5A ^ 8'(o), 8'hC3 ^ 8'(i * 17 + o), 1'b0, 1'b0);
            run_txn(3'(o), 16'h8001 + 16'(o), 8'h81 + 8'(i), 8'h3C + 8'(o * 9), 1'b0, 1'b0);
         end
      end
      // R12 request while busy, R6 divisor change mid-frame
      div = 8'd2;
      run_txn(3'd0, 16'h1234, 8'h00, 8'h9E, 1'b1, 1'b0);
      run_txn(3'd1, 16'hFEDC, 8'h77, 8'h00, 1'b1, 1'b1);
      run_txn(3'd2, 16'h0000, 8'h00, 8'h42, 1'b0, 1'b1);
      // R11 release gap between frames
      chk(gap_bad == 0, "R11 release gap", gap_bad, 0);
      // R12 unused operation codes ignored
      for (int o = 6; o < 8; o++) begin
         int falls0;
         falls0 = n_falls;
         @(negedge clk);
         op = 3'(o); req = 1'b1;
         @(negedge clk);
         req = 1'b0;
         repeat (6) @(negedge clk);
         chk(!busy && cs_n && n_falls == falls0, "R12 unused code", {busy, cs_n}, 2'b01);
      end
      chk(rdata == 8'h42, "R9 rdata kept", rdata, 8'h42);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule